// File: doc/BRIEF.md
# Two-Level Mapped Interrupt Prioritizer

This block sits behind the interrupt status latches. It receives 64 pending bits that are already enabled. Each source goes through a programmable map to one of 10 channels. Each channel then goes through a second programmable map to one of 10 host interrupt lines. For every host line the block computes the winning pending source. The winner is the source on the lowest-numbered channel, and within that channel the lowest-numbered source. The block also finds a global winner across all host lines. The winners are read back through a simple word-addressed register port, and bit 31 of each index word is a "nothing pending" flag, so software can test for a negative value.

Per-channel nesting masks come from outside on `chan_mask`. The block holds a global output enable and a per-host enable vector. The vector can be written directly, or one host at a time through an index-set word and an index-clear word. Writing the index-set word for a host that is already enabled re-triggers it. The host line drops for one cycle and then returns if work is still pending.

Writes take effect on the rising clock edge. Reads are combinational from `rd_addr`. The host outputs are combinational from the registered state and from the `pend` and `chan_mask` inputs.

Top module: `mapped_irq_prio`

## Requirements
- R1: Words 0x00–0x0F are source-to-channel maps. Word i holds 4-bit channel numbers for sources 4i, 4i+1, 4i+2 and 4i+3 at bits 3:0, 11:8, 19:16 and 27:24. All other bits read 0, and every field resets to 0.
- R2: Words 0x10–0x12 are channel-to-host maps. They use the same field layout for channels 0–3, 4–7 and 8–9. Word 0x12 keeps only bits 3:0 and 11:8. All fields reset to 0.
- R3: Word 0x20+j (j = 0..9) reads host j's winning source in bits 9:0 and sets bit 31 when nothing is pending. When bit 31 is set, bits 9:0 read 0, so after reset the word is 0x80000000.
- R4: Among the pending sources routed to a host, the lowest channel number wins. Within one channel, the lowest source number wins.
- R5: While `chan_mask[c]` is 1, channel c takes no part in any selection. A source mapped to a channel value of 10 or more reaches no host. A channel mapped to a host value of 10 or more also reaches no host.
- R6: Word 0x18 reads, in the same format, the winning source across all host lines, taken from the lowest routed, unmasked channel. It reads 0x80000000 when nothing is routed and pending.
- R7: `irq_out[j]` is 1 exactly when three things hold: the global enable (word 0x14, bit 0) is 1, host enable j is 1, and host j has a pending source. The one exception is the re-trigger gap of R9.
- R8: Word 0x15 bits 9:0 are the host enable vector. It is readable and writable directly, other bits read 0, and it resets to 0.
- R9: Writing value j < 10 to word 0x16 sets host enable j. If host enable j was already 1, `irq_out[j]` is 0 during the cycle after the write and then follows R7 again. A written value of 10 or more changes nothing, and the word reads 0.
- R10: Writing value j < 10 to word 0x17 clears host enable j. A written value of 10 or more changes nothing, and the word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Word address of the read |
| rd_data | output | 32 | Combinational read data |
| pend | input | 64 | Enabled pending source bits |
| chan_mask | input | 10 | Per-channel nesting mask, 1 excludes the channel |
| irq_out | output | 10 | Host interrupt lines |

## Verification
The assertions assume a write address is stable for the cycle of the strobe. They also assume `pend` and `chan_mask` change only between clock edges, so the host outputs observed at an edge reflect a settled selection. The bench drives every input on the falling edge and reads a little later, so both conditions hold throughout. The retrigger and clear properties also assume no second index write to the same host lands in the cycle after the first. The directed scenarios always leave at least one idle cycle between such writes.

// File: rtl/mapped_irq_prio.sv
module mapped_irq_prio #(
  parameter int NSRC  = 64,
  parameter int NCH   = 10,
  parameter int NHOST = 10,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [NSRC-1:0]  pend,
  input  logic [NCH-1:0]   chan_mask,
  output logic [NHOST-1:0] irq_out
);
  localparam int CSW    = 4;
  localparam int IDXW   = 10;
  localparam int HW     = $clog2(NHOST);
  localparam int NCMAP  = NSRC / 4;
  localparam int NHMAP  = (NCH + 3) / 4;
  localparam int A_CMAP = 0;
  localparam int A_HMAP = 16;
  localparam int A_GEN  = 20;
  localparam int A_HEN  = 21;
  localparam int A_HSET = 22;
  localparam int A_HCLR = 23;
  localparam int A_GIDX = 24;
  localparam int A_HIDX = 32;

  logic [CSW-1:0]   ch_sel   [NSRC];
  logic [CSW-1:0]   host_sel [NCH];
  logic             gen_en;
  logic [NHOST-1:0] host_en, retrig;

  logic [NCH-1:0]   ch_vld;
  logic [IDXW-1:0]  ch_idx [NCH];
  logic [NCH-1:0]   ch_live;
  logic [NHOST-1:0] h_vld;
  logic [IDXW-1:0]  h_idx [NHOST];
  logic             g_vld;
  logic [IDXW-1:0]  g_idx;
  logic             g_none;

  int               wa;
  logic             idx_ok;
  logic [HW-1:0]    widx;

  assign wa     = int'(wr_addr);
  assign idx_ok = wr_data < DW'(NHOST);
  assign widx   = wr_data[HW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) ch_sel[s] <= '0;
      for (int c = 0; c < NCH; c++) host_sel[c] <= '0;
      gen_en  <= 1'b0;
      host_en <= '0;
      retrig  <= '0;
    end else begin
      retrig <= '0;
      if (wr_en) begin
        for (int s = 0; s < NSRC; s++)
          if (wa == A_CMAP + s / 4) ch_sel[s] <= wr_data[8*(s%4) +: CSW];
        for (int c = 0; c < NCH; c++)
          if (wa == A_HMAP + c / 4) host_sel[c] <= wr_data[8*(c%4) +: CSW];
        if (wa == A_GEN) gen_en <= wr_data[0];
        if (wa == A_HEN) host_en <= wr_data[NHOST-1:0];
        if (wa == A_HSET && idx_ok) begin
          host_en[widx] <= 1'b1;
          if (host_en[widx]) retrig[widx] <= 1'b1;
        end
        if (wa == A_HCLR && idx_ok) host_en[widx] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ch_vld[c] = 1'b0;
      ch_idx[c] = '0;
      for (int s = NSRC - 1; s >= 0; s--)
        if (pend[s] && ch_sel[s] == CSW'(c)) begin
          ch_vld[c] = 1'b1;
          ch_idx[c] = IDXW'(s);
        end
    end
  end

  assign ch_live = ch_vld & ~chan_mask;

  always_comb begin
    for (int h = 0; h < NHOST; h++) begin
      h_vld[h] = 1'b0;
      h_idx[h] = '0;
      for (int c = NCH - 1; c >= 0; c--)
        if (ch_live[c] && host_sel[c] == CSW'(h)) begin
          h_vld[h] = 1'b1;
          h_idx[h] = ch_idx[c];
        end
    end
    g_vld = 1'b0;
    g_idx = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (ch_live[c] && host_sel[c] < CSW'(NHOST)) begin
        g_vld = 1'b1;
        g_idx = ch_idx[c];
      end
  end

  assign g_none  = ~g_vld;
  assign irq_out = {NHOST{gen_en}} & host_en & h_vld & ~retrig;

  always_comb begin
    int ra;
    ra      = int'(rd_addr);
    rd_data = '0;
    if (ra >= A_CMAP && ra < A_CMAP + NCMAP) begin
      for (int k = 0; k < 4; k++)
        rd_data[8*k +: CSW] = ch_sel[(ra - A_CMAP) * 4 + k];
    end else if (ra >= A_HMAP && ra < A_HMAP + NHMAP) begin
      for (int k = 0; k < 4; k++)
        if ((ra - A_HMAP) * 4 + k < NCH)
          rd_data[8*k +: CSW] = host_sel[(ra - A_HMAP) * 4 + k];
    end else if (ra == A_GEN) begin
      rd_data[0] = gen_en;
    end else if (ra == A_HEN) begin
      rd_data[NHOST-1:0] = host_en;
    end else if (ra == A_GIDX) begin
      rd_data[DW-1]     = g_none;
      rd_data[IDXW-1:0] = g_idx;
    end else if (ra >= A_HIDX && ra < A_HIDX + NHOST) begin
      rd_data[DW-1]     = ~h_vld[ra - A_HIDX];
      rd_data[IDXW-1:0] = h_idx[ra - A_HIDX];
    end
  end
endmodule

// File: rtl/mapped_irq_prio_chk.sv
module mapped_irq_prio_chk #(
  parameter int NHOST = 10,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [NHOST-1:0] irq_out,
  input logic             gen_en,
  input logic [NHOST-1:0] host_en,
  input logic             g_none
);
  localparam int HW = $clog2(NHOST);
  localparam logic [AW-1:0] A_HSET = AW'(22);
  localparam logic [AW-1:0] A_HCLR = AW'(23);

  logic          ok;
  logic [HW-1:0] hi;
  assign ok = wr_data < DW'(NHOST);
  assign hi = wr_data[HW-1:0];

  p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_HCLR && ok) |=> !irq_out[$past(hi)]);

  p_retrig_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_HSET && ok && host_en[hi]) |=> !irq_out[$past(hi)]);

  p_set_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_HSET && ok) |=> host_en[$past(hi)]);

  p_global_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> gen_en);

  p_none_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    g_none |-> (irq_out == '0));
endmodule

bind mapped_irq_prio mapped_irq_prio_chk #(.NHOST(NHOST), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq_out(irq_out), .gen_en(gen_en), .host_en(host_en), .g_none(g_none)
);

// File: tb/tb_mapped_irq_prio.sv
`timescale 1ns/1ps
module tb_mapped_irq_prio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [63:0] pend = '0;
  logic [9:0]  chan_mask = '0;
  logic [9:0]  irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mapped_irq_prio dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pend(pend), .chan_mask(chan_mask),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    rchk("R3 reset host0", 8'h20, 32'h8000_0000);
    rchk("R6 reset global", 8'h18, 32'h8000_0000);
    rchk("R1 reset cmap", 8'h05, 32'h0);
    rchk("R8 reset hen", 8'h15, 32'h0);
    chk("R7 reset irq", {22'h0, irq_out}, 32'h0);
  endtask

  task automatic t_regs;
    wr(8'h03, 32'hFFFF_FFFF);
    rchk("R1 cmap fields", 8'h03, 32'h0F0F_0F0F);
    wr(8'h03, 32'h0);
    wr(8'h12, 32'hFFFF_FFFF);
    rchk("R2 hmap last word", 8'h12, 32'h0000_0F0F);
    wr(8'h12, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rchk("R2 hmap first word", 8'h10, 32'h0F0F_0F0F);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_prio;
    @(negedge clk); pend = '0;
    rchk("R3 none pending", 8'h20, 32'h8000_0000);
    pend = (64'd1 << 5) | (64'd1 << 9);
    rchk("R4 lower source wins", 8'h20, 32'd5);
    rchk("R6 global same channel", 8'h18, 32'd5);
    wr(8'h02, 32'h0000_0100);
    wr(8'h01, 32'h0000_0300);
    rchk("R4 lower channel wins", 8'h20, 32'd9);
    wr(8'h10, 32'h0400_0200);
    rchk("R4 host2 gets ch1", 8'h22, 32'd9);
    rchk("R4 host4 gets ch3", 8'h24, 32'd5);
    rchk("R3 host0 empty", 8'h20, 32'h8000_0000);
    rchk("R6 global lowest channel", 8'h18, 32'd9);
  endtask

  task automatic t_mask;
    @(negedge clk); chan_mask = 10'b00_0000_0010;
    rchk("R5 masked channel host2", 8'h22, 32'h8000_0000);
    rchk("R5 masked channel global", 8'h18, 32'd5);
    @(negedge clk); chan_mask = '0;
    wr(8'h02, 32'h0000_0C00);
    rchk("R5 channel out of range", 8'h22, 32'h8000_0000);
    rchk("R5 global after unroute", 8'h18, 32'd5);
    wr(8'h10, 32'h0B00_0200);
    rchk("R5 host out of range", 8'h24, 32'h8000_0000);
    rchk("R6 nothing routed", 8'h18, 32'h8000_0000);
    wr(8'h10, 32'h0); wr(8'h01, 32'h0); wr(8'h02, 32'h0);
    @(negedge clk); pend = '0;
  endtask

  task automatic t_outputs;
    @(negedge clk); pend = 64'd1 << 5;
    chk("R7 all disabled", {22'h0, irq_out}, 32'h0);
    wr(8'h15, 32'h1);
    rchk("R8 hen write", 8'h15, 32'h1);
    chk("R7 global enable off", {22'h0, irq_out}, 32'h0);
    wr(8'h14, 32'h1);
    chk("R7 host0 asserted", {22'h0, irq_out}, 32'h1);
    @(negedge clk); pend = '0; #1;
    chk("R7 nothing pending", {22'h0, irq_out}, 32'h0);
    @(negedge clk); pend = 64'd1 << 5;
    wr(8'h15, 32'hFFFF_FFFF);
    rchk("R8 hen width", 8'h15, 32'h3FF);
    wr(8'h15, 32'h0);
  endtask

  task automatic t_retrig;
    wr(8'h16, 32'd0);
    rchk("R9 set enables", 8'h15, 32'h1);
    chk("R9 first set no gap", {22'h0, irq_out}, 32'h1);
    wr(8'h16, 32'd0);
    chk("R9 retrigger gap", {22'h0, irq_out}, 32'h0);
    @(negedge clk); #1;
    chk("R9 reasserted", {22'h0, irq_out}, 32'h1);
    wr(8'h16, 32'd12);
    rchk("R9 bad index ignored", 8'h15, 32'h1);
    rchk("R9 set word reads 0", 8'h16, 32'h0);
  endtask

  task automatic t_clear;
    wr(8'h17, 32'd0);
    chk("R10 clear drops line", {22'h0, irq_out}, 32'h0);
    rchk("R10 clear hen", 8'h15, 32'h0);
    wr(8'h15, 32'h3FF);
    wr(8'h17, 32'd10);
    rchk("R10 bad index ignored", 8'h15, 32'h3FF);
    wr(8'h17, 32'd3);
    rchk("R10 clear host3", 8'h15, 32'h3F7);
    rchk("R10 clear word reads 0", 8'h17, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_prio;
    t_mask;
    t_outputs;
    t_retrig;
    t_clear;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule